// File: doc/BRIEF.md
# SPI CRC Generator and Checker

This block sits next to an SPI shift register and protects the data stream with a cyclic redundancy check. It has two independent calculators. One runs over the transmitted bits and one over the received bits. Each advances by one bit for every SCLK sampling pulse the shifter reports, MSB first. The frame width is 8 or 16 bits. It selects the CRC width, and the generator polynomial comes from a programmable input with an implicit top term.

Software ends a stream with a one-shot "CRC follows" request, issued while the last data frame is still in flight. In DMA mode, the transfer-count-reached strobe ends the stream instead. In both cases the next frame becomes the CRC frame. On the transmit side the engine tells the shifter to take CRC bits in place of data. On the receive side it captures the incoming frame and compares it with its own receive CRC. A mismatch sets a sticky error flag, and the interrupt output follows that flag when the error interrupt is enabled.

Once the CRC frame has passed, both calculators freeze until software resynchronises. To resynchronise, it stops the SPI, clears the CRC enable, sets it again and restarts the SPI. The rising edge of the enable zeroes both registers. The engine has no chip-select qualification: in slave mode it counts every SCLK pulse, including pulses seen while the slave is deselected.

Top module: `spi_crc_engine`

## Requirements
- R1: After reset, tx_use_crc, tx_crc_bit, tx_crc, rx_crc, crc_err and irq are all zero.
- R2: With frame16=0 the CRC is 8 bits wide. Only poly[7:0] is used, bit 7 is the top bit, and tx_crc[15:8] and rx_crc[15:8] stay zero. With frame16=1 all 16 bits are used.
- R3: Each accepted pulse advances both CRCs, starting from zero. Let fb be the CRC top bit XOR the incoming bit. The new CRC is (crc<<1) XOR (fb ? poly : 0), truncated to the CRC width. tx_crc runs only over tx_bit and rx_crc runs only over rx_bit.
- R4: While crc_en is low, sclk_pulse has no effect and both CRC registers hold their values.
- R5: In the cycle after crc_en rises, tx_crc and rx_crc read zero, the bit position is back at the start of a frame, and any end-of-stream request is cleared.
- R6: A crc_next pulse issued during a data frame makes the frame that follows it the CRC frame. The previous frame must be complete, and crc_next must come at least one cycle before the last bit pulse. tx_use_crc is high for exactly that one frame. At the k-th pulse of that frame (k=0 first), tx_crc_bit equals tx_crc bit [width-1-k].
- R7: From the start of the CRC frame until crc_en rises again, tx_crc and rx_crc do not change, whatever the pulses.
- R8: During the CRC frame the received bits are collected MSB first. One clock after the last CRC bit pulse, crc_err is set if the collected value differs from rx_crc over the CRC width. A match leaves crc_err unchanged.
- R9: crc_err stays set until an err_clr pulse. If a new mismatch and err_clr arrive in the same cycle, the flag stays set.
- R10: irq is high exactly when crc_err is high and err_ie is high.
- R11: With dma_en high, a dma_last pulse between frames (no sclk_pulse in that cycle) turns the next frame into the CRC frame without crc_next. tx_use_crc is high in the following cycle.
- R12: No chip-select input gates the calculators. Every pulse counts, including pulses a slave sees while the master has it deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_en | input | 1 | CRC enable; rising edge clears both calculators |
| frame16 | input | 1 | 1: 16-bit frames and CRC, 0: 8-bit |
| poly | input | 16 | Generator polynomial without the implicit top term |
| sclk_pulse | input | 1 | One pulse per SCLK sampling edge from the shifter |
| tx_bit | input | 1 | Transmitted bit at this pulse |
| rx_bit | input | 1 | Received bit at this pulse |
| crc_next | input | 1 | Software request: frame after the current one is the CRC |
| dma_en | input | 1 | DMA mode enable |
| dma_last | input | 1 | DMA transfer count reached |
| err_ie | input | 1 | Error interrupt enable |
| err_clr | input | 1 | Clears the CRC error flag |
| tx_use_crc | output | 1 | Shifter must send CRC bits for this frame |
| tx_crc_bit | output | 1 | CRC bit to send at the current pulse |
| tx_crc | output | 16 | Transmit CRC register |
| rx_crc | output | 16 | Receive CRC register |
| crc_err | output | 1 | Sticky CRC mismatch flag |
| irq | output | 1 | Error interrupt |

## Verification
The inline assertions watch five things on every cycle. They check that the upper byte stays zero in narrow mode and that both registers read zero right after the enable rises. They also check that both registers stay frozen once the CRC frame has started, that the error flag is sticky, and that the flag can only rise two cycles after a CRC frame ends. The other behaviours depend on whole transfers, so only the bench scenarios can show them. These are the exact CRC value for a given polynomial and data, the MSB-first order of the transmitted CRC bits, and the one-frame look-ahead of the software request against the immediate take-over on the DMA strobe. The same holds for detecting a corrupted received CRC, for pulses being ignored while disabled, and for pulses counting with no select qualification.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;

   typedef enum logic [1:0] {
      PH_DATA   = 2'd0,
      PH_CRC    = 2'd1,
      PH_SEALED = 2'd2
   } crc_phase_e;

endpackage

// File: rtl/spi_crc_lfsr.sv
module spi_crc_lfsr #(
   parameter int W  = 16,
   parameter int NW = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic         wide,
   input  logic         din,
   input  logic [W-1:0] poly,
   output logic [W-1:0] crc
);

   logic [W-1:0] crc_q;
   logic [W-1:0] nxt;
   logic         fb;

   generate
      if (NW < 2 || NW >= W) begin : g_bad_width
         $error("spi_crc_lfsr: NW must be at least 2 and below W");
      end
   endgenerate

   assign fb = (wide ? crc_q[W-1] : crc_q[NW-1]) ^ din;

   generate
      for (genvar i = 0; i < W; i++) begin : g_tap
         if (i == 0) begin : g_lsb
            assign nxt[i] = fb & poly[i];
         end else if (i < NW) begin : g_low
            assign nxt[i] = crc_q[i-1] ^ (fb & poly[i]);
         end else begin : g_high
            assign nxt[i] = wide & (crc_q[i-1] ^ (fb & poly[i]));
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc_q <= '0;
      else if (clr)  crc_q <= '0;
      else if (step) crc_q <= nxt;
   end

   assign crc = crc_q;

   // R2
   narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wide) |=> (crc_q[W-1:NW] == '0));

endmodule

// File: rtl/spi_crc_seq.sv
module spi_crc_seq
   import spi_crc_pkg::*;
#(
   parameter int W  = 16,
   parameter int NW = 8,
   localparam int BW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          clr,
   input  logic          wide,
   input  logic          pulse,
   input  logic          arm_sw,
   input  logic          arm_dma,
   output crc_phase_e    phase,
   output logic [BW-1:0] bit_idx,
   output logic [BW-1:0] top_idx,
   output logic          calc_step,
   output logic          crc_done
);

   crc_phase_e    ph_q;
   logic [BW-1:0] idx_q;
   logic          pend_q;
   logic          frame_end;

   assign top_idx   = wide ? BW'(W - 1) : BW'(NW - 1);
   assign frame_end = en && pulse && (idx_q == top_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_DATA;
         idx_q  <= '0;
         pend_q <= 1'b0;
      end else if (clr) begin
         ph_q   <= PH_DATA;
         idx_q  <= '0;
         pend_q <= 1'b0;
      end else if (en) begin
         if (pulse) idx_q <= frame_end ? '0 : idx_q + 1'b1;
         unique case (ph_q)
            PH_DATA: begin
               if (frame_end && (pend_q || arm_sw)) begin
                  ph_q   <= PH_CRC;
                  pend_q <= 1'b0;
               end else if (arm_dma && !pulse && idx_q == '0) begin
                  ph_q   <= PH_CRC;
                  pend_q <= 1'b0;
               end else if (arm_sw) begin
                  pend_q <= 1'b1;
               end
            end
            PH_CRC:    if (frame_end) ph_q <= PH_SEALED;
            default:   ph_q <= PH_SEALED;
         endcase
      end
   end

   assign phase     = ph_q;
   assign bit_idx   = idx_q;
   assign calc_step = en && pulse && (ph_q == PH_DATA);
   assign crc_done  = frame_end && (ph_q == PH_CRC);

   // R7
   sealed_no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_SEALED && !clr) |=> (ph_q != PH_CRC));

endmodule

// File: rtl/spi_crc_rxchk.sv
module spi_crc_rxchk #(
   parameter int W  = 16,
   parameter int NW = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         wide,
   input  logic         cap_en,
   input  logic         rx_bit,
   input  logic         done,
   input  logic [W-1:0] ref_crc,
   input  logic         err_clr,
   output logic         crc_err
);

   logic [W-1:0] cap_q;
   logic         done_q;
   logic         err_q;
   logic         mismatch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q <= '0;
      else if (clr)    cap_q <= '0;
      else if (cap_en) cap_q <= {cap_q[W-2:0], rx_bit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= done;
   end

   assign mismatch = wide ? (cap_q != ref_crc)
                          : (cap_q[NW-1:0] != ref_crc[NW-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  err_q <= 1'b0;
      else if (done_q && mismatch) err_q <= 1'b1;
      else if (err_clr)            err_q <= 1'b0;
   end

   assign crc_err = err_q;

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !err_clr) |=> err_q);

   // R8
   err_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(done, 2));

endmodule

// File: rtl/spi_crc_engine.sv
module spi_crc_engine
   import spi_crc_pkg::*;
#(
   parameter int W  = 16,
   parameter int NW = 8,
   localparam int BW = $clog2(W)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         crc_en,
   input  logic         frame16,
   input  logic [W-1:0] poly,
   input  logic         sclk_pulse,
   input  logic         tx_bit,
   input  logic         rx_bit,
   input  logic         crc_next,
   input  logic         dma_en,
   input  logic         dma_last,
   input  logic         err_ie,
   input  logic         err_clr,
   output logic         tx_use_crc,
   output logic         tx_crc_bit,
   output logic [W-1:0] tx_crc,
   output logic [W-1:0] rx_crc,
   output logic         crc_err,
   output logic         irq
);

   localparam int NCALC = 2;

   logic          en_q;
   logic          clr;
   crc_phase_e    phase;
   logic [BW-1:0] bit_idx;
   logic [BW-1:0] top_idx;
   logic          calc_step;
   logic          crc_done;
   logic          in_crc;
   logic [W-1:0]  crc_q [NCALC];
   logic [NCALC-1:0] din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= crc_en;
   end

   assign clr = crc_en && !en_q;

   spi_crc_seq #(.W(W), .NW(NW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (crc_en),
      .clr       (clr),
      .wide      (frame16),
      .pulse     (sclk_pulse),
      .arm_sw    (crc_next),
      .arm_dma   (dma_en && dma_last),
      .phase     (phase),
      .bit_idx   (bit_idx),
      .top_idx   (top_idx),
      .calc_step (calc_step),
      .crc_done  (crc_done)
   );

   assign din = {rx_bit, tx_bit};

   generate
      for (genvar g = 0; g < NCALC; g++) begin : g_calc
         spi_crc_lfsr #(.W(W), .NW(NW)) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .step  (calc_step),
            .wide  (frame16),
            .din   (din[g]),
            .poly  (poly),
            .crc   (crc_q[g])
         );
      end
   endgenerate

   assign tx_crc = crc_q[0];
   assign rx_crc = crc_q[1];
   assign in_crc = (phase == PH_CRC);

   spi_crc_rxchk #(.W(W), .NW(NW)) u_rxchk (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .wide    (frame16),
      .cap_en  (in_crc && crc_en && sclk_pulse),
      .rx_bit  (rx_bit),
      .done    (crc_done),
      .ref_crc (rx_crc),
      .err_clr (err_clr),
      .crc_err (crc_err)
   );

   assign tx_use_crc = in_crc;
   assign tx_crc_bit = in_crc && tx_crc[top_idx - bit_idx];
   assign irq        = crc_err && err_ie;

   // R5
   enable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_en) |=> (tx_crc == '0 && rx_crc == '0));

   // R7
   frozen_after_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(phase) != PH_DATA && phase != PH_DATA) |->
         ($stable(tx_crc) && $stable(rx_crc)));

endmodule

// File: tb/tb_spi_crc_engine.sv
`timescale 1ns/1ps
module tb_spi_crc_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        crc_en = 1'b0, frame16 = 1'b0;
   logic [15:0] poly = '0;
   logic        sclk_pulse = 1'b0, tx_bit = 1'b0, rx_bit = 1'b0;
   logic        crc_next = 1'b0, dma_en = 1'b0, dma_last = 1'b0;
   logic        err_ie = 1'b0, err_clr = 1'b0;
   logic        tx_use_crc, tx_crc_bit, crc_err, irq;
   logic [15:0] tx_crc, rx_crc;

   int n_chk = 0, n_fail = 0;
   logic [15:0] exp_tx, exp_rx;
   bit finished = 0;

   always #2 clk = ~clk;

   spi_crc_engine dut (
      .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .frame16(frame16), .poly(poly),
      .sclk_pulse(sclk_pulse), .tx_bit(tx_bit), .rx_bit(rx_bit),
      .crc_next(crc_next), .dma_en(dma_en), .dma_last(dma_last),
      .err_ie(err_ie), .err_clr(err_clr), .tx_use_crc(tx_use_crc),
      .tx_crc_bit(tx_crc_bit), .tx_crc(tx_crc), .rx_crc(rx_crc),
      .crc_err(crc_err), .irq(irq)
   );

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b,
                                            input logic w, input logic [15:0] p);
      logic [15:0] m = w ? 16'hFFFF : 16'h00FF;
      logic f = (w ? c[15] : c[7]) ^ b;
      return ((c << 1) ^ (f ? p : 16'h0)) & m;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic one_bit(input logic tb_b, input logic rb, input bit upd);
      sclk_pulse = 1'b1; tx_bit = tb_b; rx_bit = rb;
      if (upd) begin
         exp_tx = crc_step(exp_tx, tb_b, frame16, poly);
         exp_rx = crc_step(exp_rx, rb, frame16, poly);
      end
      tick();
      sclk_pulse = 1'b0;
   endtask

   task automatic data_frame(input logic [15:0] td, input logic [15:0] rd, input bit upd);
      for (int i = (frame16 ? 15 : 7); i >= 0; i--) one_bit(td[i], rd[i], upd);
   endtask

   task automatic resync(input logic w, input logic [15:0] p);
      crc_en = 1'b0; tick();
      frame16 = w; poly = p;
      crc_en = 1'b1; tick();
      exp_tx = '0; exp_rx = '0;
      check("R5 tx cleared", tx_crc, 16'h0);
      check("R5 rx cleared", rx_crc, 16'h0);
   endtask

   task automatic pulse_clr();
      err_clr = 1'b1; tick(); err_clr = 1'b0;
   endtask

   task automatic xfer(input int nfr, input bit use_dma, input bit corrupt);
      logic [15:0] hold;
      int top = frame16 ? 15 : 7;
      dma_en = use_dma;
      for (int k = 0; k < nfr; k++) begin
         if (!use_dma && k == nfr - 1) begin
            crc_next = 1'b1; tick(); crc_next = 1'b0;
         end
         data_frame(16'($urandom), 16'($urandom), 1'b1);
      end
      // R3 both calculators against the model
      check("R3 tx crc", tx_crc, exp_tx);
      check("R3 rx crc", rx_crc, exp_rx);
      if (!frame16) check("R2 upper byte zero", {tx_crc[15:8], rx_crc[15:8]}, 16'h0);
      if (use_dma) begin
         dma_last = 1'b1; tick(); dma_last = 1'b0;
         check("R11 dma takes crc", {15'h0, tx_use_crc}, 16'h1);
      end else begin
         check("R6 crc frame flagged", {15'h0, tx_use_crc}, 16'h1);
      end
      for (int i = top; i >= 0; i--) begin
         check("R6 crc bit order", {15'h0, tx_crc_bit}, {15'h0, exp_tx[i]});
         one_bit(1'b0, exp_rx[i] ^ (corrupt && i == 0), 1'b0);
      end
      check("R6 one crc frame only", {15'h0, tx_use_crc}, 16'h0);
      tick();
      check("R8 compare result", {15'h0, crc_err}, {15'h0, corrupt});
      hold = tx_crc;
      data_frame(16'($urandom), 16'($urandom), 1'b0);
      check("R7 tx frozen", tx_crc, hold);
      check("R7 rx frozen", rx_crc, exp_rx);
      dma_en = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) tick();
      rst_n = 1'b1; tick();
      check("R1 reset outputs", {12'h0, tx_use_crc, tx_crc_bit, crc_err, irq}, 16'h0);
      check("R1 reset crc", tx_crc | rx_crc, 16'h0);

      // 8-bit, polynomial upper byte must be ignored
      err_ie = 1'b1;
      resync(1'b0, 16'hFF07);
      xfer(5, 1'b0, 1'b0);
      check("R10 irq quiet", {15'h0, irq}, 16'h0);

      // 16-bit with corrupted received CRC
      resync(1'b1, 16'h8005);
      xfer(4, 1'b0, 1'b1);
      check("R10 irq on error", {15'h0, irq}, 16'h1);
      err_ie = 1'b0; tick();
      check("R10 irq masked", {15'h0, irq}, 16'h0);
      repeat (5) tick();
      check("R9 sticky", {15'h0, crc_err}, 16'h1);
      pulse_clr();
      check("R9 cleared", {15'h0, crc_err}, 16'h0);

      // R4 disabled: pulses ignored
      resync(1'b1, 16'h1021);
      data_frame(16'h1234, 16'h5678, 1'b1);
      crc_en = 1'b0; tick();
      data_frame(16'hFFFF, 16'hA5A5, 1'b0);
      check("R4 tx held", tx_crc, exp_tx);
      check("R4 rx held", rx_crc, exp_rx);
      crc_en = 1'b1; tick();
      check("R5 re-enable clears", tx_crc | rx_crc, 16'h0);

      // R12 master keeps the slave deselected: pulses still count
      exp_tx = '0; exp_rx = '0;
      data_frame(16'hC3A1, 16'h0F0F, 1'b1);
      check("R12 tx counts while deselected", tx_crc, exp_tx);
      check("R12 rx counts while deselected", rx_crc, exp_rx);

      // DMA end of transfer
      resync(1'b1, 16'h8005);
      xfer(3, 1'b1, 1'b0);
      resync(1'b0, 16'h0031);
      xfer(2, 1'b1, 1'b1);
      pulse_clr();

      // random mix
      for (int r = 0; r < 8; r++) begin
         resync(1'($urandom), 16'($urandom) | 16'h1);
         xfer(2 + int'($urandom % 5), 1'($urandom), 1'($urandom));
         pulse_clr();
         check("R9 clear between runs", {15'h0, crc_err}, 16'h0);
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule